// File: doc/BRIEF.md
# Token-ring reconfiguration sequencer

This block is the control state machine that lets one node of a token-passing network rebuild the logical ring on its own. It starts with a reconfigure burst, listens for an idle line, and waits out a backoff that gets shorter as the node ID gets higher. If the line is still quiet at the end of the backoff, the node claims the right to send invitations. It then searches upward through the ID space for its successor and stores the successor's ID as the next-node register. When an invitation addressed to this node arrives, the block takes the token. It asks the transmitter for a free-buffer enquiry if a transmit is pending, and afterwards passes the token on to the stored successor.

Time is counted in unit ticks of one 200 ns interval at the base rate. The `tick` input supplies them. A rate-select input multiplies every terminal count by a power of two for slower line rates. The receive path supplies frame decoding and a line-activity flag, and the transmit path turns the request pulses into frames. Both paths are outside this block.

Top module: `rcfg_token_seq`

## Requirements
- R1: After reset, or one clock after a `sw_reset` pulse, `burst_on` is 1, and `itt_req`, `enq_req` and `have_token` are 0.
- R2: A reconfigure burst lasts 6885 unit ticks × scale, which is 765 repeats of a 9-interval pattern. Then `burst_on` falls and the node starts listening.
- R3: While listening, 205 × scale quiet ticks start the backoff. The backoff lasts (255 − `node_id`) × 365 × scale quiet ticks.
- R4: When the backoff ends with the line quiet, `itt_req` pulses for one clock with `itt_dest` = `node_id`, and `next_id` becomes `node_id`.
- R5: After each invitation, 187 × scale quiet ticks make the node add one to `next_id` and pulse `itt_req` with the new value as `itt_dest`. `next_id` only changes in a clock where `itt_req` is 1.
- R6: Stepping from 255 wraps to 1. An invitation with `node_id` nonzero never carries destination 0.
- R7: `line_active` during backoff or during the search returns the node to listening and restarts the idle count. The next claim again starts at the node's own ID.
- R8: `rate_sel` = k multiplies every terminal count by 2^k. Values above 5 act as 5.
- R9: `rx_itt_own` while listening, in backoff or searching sets `have_token` one clock later. `enq_req` pulses at the same time if `tx_pending` is 1. The token is passed when `xfer_done` arrives (or one clock later if nothing was pending): `itt_req` pulses with `itt_dest` = `next_id` and `have_token` drops.
- R10: If no own invitation has been taken for the reconfiguration limit (× scale), a new burst starts. `recon_sel` picks one of four limits, given by the parameters RECON_T0..RECON_T3.
- R11: During a burst, `rx_itt_own` and `xfer_done` have no effect. `have_token` and `enq_req` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One unit-interval strobe |
| node_id | input | 8 | This node's ID (1..255) |
| rate_sel | input | 3 | Timeout scale exponent |
| recon_sel | input | 2 | Reconfiguration limit select |
| sw_reset | input | 1 | Software reset pulse, starts a burst |
| line_active | input | 1 | Activity from other nodes seen on the line |
| rx_itt_own | input | 1 | Decoded invitation addressed to this node |
| tx_pending | input | 1 | A packet waits to be sent |
| xfer_done | input | 1 | Enquiry/packet exchange finished |
| burst_on | output | 1 | Transmitter must send the reconfigure burst |
| itt_req | output | 1 | One-clock request to send an invitation |
| itt_dest | output | 8 | Destination of the requested invitation |
| enq_req | output | 1 | One-clock request to send a free-buffer enquiry |
| next_id | output | 8 | Stored successor ID |
| have_token | output | 1 | Node holds the token |

## Verification
A phase counter compared against the wrong limit shows up at once as a shifted `burst_on` fall or a shifted `itt_req` pulse. The bench measures these delays to within a few clocks for the burst, idle, backoff, search and reconfiguration windows. A corrupted successor register shows up on the very next invitation, as a wrong `itt_dest` or a destination of 0 at the wrap. A wrong state shows up within one clock, as `have_token` or `enq_req` appearing during a burst, or as an invitation that keeps coming after line activity.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  localparam int ID_W = 8;

  typedef enum logic [2:0] {
    ST_BURST,
    ST_WATCH,
    ST_BACKOFF,
    ST_SWEEP,
    ST_HOLD
  } seq_state_e;

  // successor ID: wraps past the top value to 1, never to the broadcast ID 0
  function automatic logic [ID_W-1:0] step_id(input logic [ID_W-1:0] cur);
    if (cur == {ID_W{1'b1}}) step_id = ID_W'(1);
    else                     step_id = cur + 1'b1;
  endfunction
endpackage

// File: rtl/rcfg_limit_calc.sv
module rcfg_limit_calc #(
  parameter int unsigned LIM_W     = 32,
  parameter int unsigned ID_W      = 8,
  parameter int unsigned RATE_W    = 3,
  parameter int unsigned MAX_SHIFT = 5,
  parameter int unsigned IDLE_T    = 205,
  parameter int unsigned RESP_T    = 187,
  parameter int unsigned SLOT_T    = 365,
  parameter int unsigned BURST_T   = 6885,
  parameter int unsigned RECON_T0  = 2100000,
  parameter int unsigned RECON_T1  = 1050000,
  parameter int unsigned RECON_T2  = 4200000,
  parameter int unsigned RECON_T3  = 8400000
) (
  input  logic [ID_W-1:0]   node_id,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [1:0]        recon_sel,
  output logic [LIM_W-1:0]  idle_lim,
  output logic [LIM_W-1:0]  resp_lim,
  output logic [LIM_W-1:0]  backoff_lim,
  output logic [LIM_W-1:0]  burst_lim,
  output logic [LIM_W-1:0]  recon_lim
);
  localparam int unsigned TOP_ID = (1 << ID_W) - 1;

  logic [RATE_W-1:0] shamt;
  logic [LIM_W-1:0]  rank;
  logic [LIM_W-1:0]  recon_base;

  always_comb begin
    shamt = (rate_sel > RATE_W'(MAX_SHIFT)) ? RATE_W'(MAX_SHIFT) : rate_sel;
    rank  = LIM_W'(TOP_ID) - LIM_W'(node_id);
    case (recon_sel)
      2'd0:    recon_base = LIM_W'(RECON_T0);
      2'd1:    recon_base = LIM_W'(RECON_T1);
      2'd2:    recon_base = LIM_W'(RECON_T2);
      default: recon_base = LIM_W'(RECON_T3);
    endcase
    idle_lim    = LIM_W'(IDLE_T)  << shamt;
    resp_lim    = LIM_W'(RESP_T)  << shamt;
    burst_lim   = LIM_W'(BURST_T) << shamt;
    backoff_lim = (rank * LIM_W'(SLOT_T)) << shamt;
    recon_lim   = recon_base << shamt;
  end
endmodule

// File: rtl/rcfg_interval_timer.sv
module rcfg_interval_timer #(
  parameter int unsigned LIM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic [LIM_W-1:0] limit,
  output logic             expired
);
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = run && tick && (cnt_q < limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q >= limit);

  // R2: every window restarts from zero after a clear
  assert_timer_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/rcfg_token_seq.sv
module rcfg_token_seq
  import rcfg_pkg::*;
#(
  parameter int unsigned LIM_W     = 32,
  parameter int unsigned RATE_W    = 3,
  parameter int unsigned MAX_SHIFT = 5,
  parameter int unsigned IDLE_T    = 205,
  parameter int unsigned RESP_T    = 187,
  parameter int unsigned SLOT_T    = 365,
  parameter int unsigned BURST_T   = 6885,
  parameter int unsigned RECON_T0  = 2100000,
  parameter int unsigned RECON_T1  = 1050000,
  parameter int unsigned RECON_T2  = 4200000,
  parameter int unsigned RECON_T3  = 8400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ID_W-1:0]   node_id,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [1:0]        recon_sel,
  input  logic              sw_reset,
  input  logic              line_active,
  input  logic              rx_itt_own,
  input  logic              tx_pending,
  input  logic              xfer_done,
  output logic              burst_on,
  output logic              itt_req,
  output logic [ID_W-1:0]   itt_dest,
  output logic              enq_req,
  output logic [ID_W-1:0]   next_id,
  output logic              have_token
);
  seq_state_e state_q, state_d;
  logic [ID_W-1:0] nid_q, nid_d;
  logic [ID_W-1:0] dest_q, dest_d;
  logic            itt_q, enq_q, hold_wait_q, hold_wait_d;

  logic [LIM_W-1:0] idle_lim, resp_lim, backoff_lim, burst_lim, recon_lim;
  logic [LIM_W-1:0] phase_lim;
  logic phase_exp, phase_clr, phase_run;
  logic recon_exp, recon_clr;
  logic go_burst, take, pass, claim, step, itt_fire, can_take;

  rcfg_limit_calc #(
    .LIM_W(LIM_W), .ID_W(ID_W), .RATE_W(RATE_W), .MAX_SHIFT(MAX_SHIFT),
    .IDLE_T(IDLE_T), .RESP_T(RESP_T), .SLOT_T(SLOT_T), .BURST_T(BURST_T),
    .RECON_T0(RECON_T0), .RECON_T1(RECON_T1), .RECON_T2(RECON_T2), .RECON_T3(RECON_T3)
  ) u_lim (
    .node_id(node_id), .rate_sel(rate_sel), .recon_sel(recon_sel),
    .idle_lim(idle_lim), .resp_lim(resp_lim), .backoff_lim(backoff_lim),
    .burst_lim(burst_lim), .recon_lim(recon_lim)
  );

  // phase window: burst length, idle detection, backoff, response wait
  rcfg_interval_timer #(.LIM_W(LIM_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(phase_run), .clr(phase_clr),
    .limit(phase_lim), .expired(phase_exp)
  );

  // time since this node last took the token
  rcfg_interval_timer #(.LIM_W(LIM_W)) u_recon (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(1'b1), .clr(recon_clr),
    .limit(recon_lim), .expired(recon_exp)
  );

  always_comb begin
    case (state_q)
      ST_BURST:   phase_lim = burst_lim;
      ST_WATCH:   phase_lim = idle_lim;
      ST_BACKOFF: phase_lim = backoff_lim;
      ST_SWEEP:   phase_lim = resp_lim;
      default:    phase_lim = '0;
    endcase
  end

  assign go_burst = sw_reset || recon_exp;
  assign can_take = (state_q == ST_WATCH) || (state_q == ST_BACKOFF) || (state_q == ST_SWEEP);
  assign take     = rx_itt_own && can_take && !go_burst;
  assign claim    = (state_q == ST_BACKOFF) && phase_exp && !line_active && !take && !go_burst;
  assign step     = (state_q == ST_SWEEP) && phase_exp && !line_active && !take && !go_burst;
  assign pass     = (state_q == ST_HOLD) && (!hold_wait_q || xfer_done) && !go_burst;
  assign itt_fire = claim || step || pass;

  always_comb begin
    state_d = state_q;
    if (go_burst) begin
      state_d = ST_BURST;
    end else begin
      case (state_q)
        ST_BURST: if (phase_exp) state_d = ST_WATCH;
        ST_WATCH: begin
          if (take)                          state_d = ST_HOLD;
          else if (phase_exp && !line_active) state_d = ST_BACKOFF;
        end
        ST_BACKOFF: begin
          if (take)             state_d = ST_HOLD;
          else if (line_active) state_d = ST_WATCH;
          else if (claim)       state_d = ST_SWEEP;
        end
        ST_SWEEP: begin
          if (take)             state_d = ST_HOLD;
          else if (line_active) state_d = ST_WATCH;
        end
        ST_HOLD: if (pass) state_d = ST_SWEEP;
        default: state_d = ST_BURST;
      endcase
    end
  end

  assign phase_run = (state_q != ST_HOLD);
  assign phase_clr = go_burst || (state_d != state_q) || itt_fire ||
                     (line_active && (state_q == ST_WATCH));
  assign recon_clr = go_burst || take || (state_q == ST_BURST);

  always_comb begin
    nid_d       = nid_q;
    dest_d      = dest_q;
    hold_wait_d = hold_wait_q;
    if (claim) begin
      nid_d  = node_id;
      dest_d = node_id;
    end else if (step) begin
      nid_d  = step_id(nid_q);
      dest_d = step_id(nid_q);
    end else if (pass) begin
      dest_d = nid_q;
    end
    if (take) hold_wait_d = tx_pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_BURST;
      nid_q       <= ID_W'(1);
      dest_q      <= '0;
      itt_q       <= 1'b0;
      enq_q       <= 1'b0;
      hold_wait_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      nid_q       <= nid_d;
      dest_q      <= dest_d;
      itt_q       <= itt_fire;
      enq_q       <= take && tx_pending;
      hold_wait_q <= hold_wait_d;
    end
  end

  assign burst_on   = (state_q == ST_BURST);
  assign have_token = (state_q == ST_HOLD);
  assign itt_req    = itt_q;
  assign itt_dest   = dest_q;
  assign enq_req    = enq_q;
  assign next_id    = nid_q;

  assert_dest_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (itt_req && (node_id != '0)) |-> (itt_dest != '0));
  assert_enq_with_token_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enq_req |-> have_token);
  assert_token_from_invite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(have_token) |-> $past(rx_itt_own));
  assert_nid_moves_with_itt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (next_id != $past(next_id)) |-> itt_req);
  assert_no_itt_in_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
    burst_on |-> (!itt_req && !have_token));
endmodule

// File: tb/sim_rcfg_token_seq.sv
`timescale 1ns/1ps
module sim_rcfg_token_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [7:0] node_id;
  logic [2:0] rate_sel;
  logic [1:0] recon_sel;
  logic       sw_reset, line_active, rx_itt_own, tx_pending, xfer_done;
  logic       burst_on, itt_req, enq_req, have_token;
  logic [7:0] itt_dest, next_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rcfg_token_seq #(
    .RECON_T0(100000), .RECON_T1(9000), .RECON_T2(20000), .RECON_T3(40000)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .node_id(node_id), .rate_sel(rate_sel),
    .recon_sel(recon_sel), .sw_reset(sw_reset), .line_active(line_active),
    .rx_itt_own(rx_itt_own), .tx_pending(tx_pending), .xfer_done(xfer_done),
    .burst_on(burst_on), .itt_req(itt_req), .itt_dest(itt_dest), .enq_req(enq_req),
    .next_id(next_id), .have_token(have_token)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // counts negedges while burst_on stays high
  task automatic burst_len(output int n);
    n = 0;
    while (burst_on && n < 300000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_sw_reset();
    @(negedge clk); sw_reset = 1'b1;
    @(negedge clk); sw_reset = 1'b0;
  endtask

  task automatic wait_itt(input int max, output int k);
    k = 0;
    while (!itt_req && k < max) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset_and_burst();
    int n;
    chk(burst_on == 1'b1, "R1", "burst_on after reset", burst_on, 1);
    chk(!itt_req && !enq_req && !have_token, "R1", "req/token after reset",
        {itt_req, enq_req, have_token}, 0);
    burst_len(n);
    chk(n >= 6885 && n <= 6888, "R2", "burst length", n, 6885);
  endtask

  task automatic t_claim_and_sweep();
    int k;
    wait_itt(5000, k);
    chk(k >= 2030 && k <= 2034, "R3", "idle+backoff delay", k, 205 + 5 * 365);
    chk(itt_dest == 8'd250, "R4", "claim destination", itt_dest, 250);
    chk(next_id == 8'd250, "R4", "next_id after claim", next_id, 250);
    @(negedge clk);
    wait_itt(1000, k);
    chk(k >= 186 && k <= 190, "R5", "response window", k + 1, 188);
    chk(itt_dest == 8'd251 && next_id == 8'd251, "R5", "stepped destination", itt_dest, 251);
    // another node answers: release control
    repeat (20) @(negedge clk);
    line_active = 1'b1;
    repeat (3) @(negedge clk);
    line_active = 1'b0;
    wait_itt(1800, k);
    chk(!itt_req, "R7", "no invitation after release", itt_req, 0);
    wait_itt(3000, k);
    chk(itt_req && itt_dest == 8'd250, "R7", "new claim restarts at own ID", itt_dest, 250);
  endtask

  task automatic t_backoff_restart();
    int n, k;
    pulse_sw_reset();
    burst_len(n);
    repeat (700) @(negedge clk);
    chk(!itt_req, "R3", "no claim before backoff end", itt_req, 0);
    line_active = 1'b1;
    @(negedge clk);
    line_active = 1'b0;
    wait_itt(5000, k);
    chk(k >= 2030 && k <= 2034, "R7", "delay after activity in backoff", k, 2031);
  endtask

  task automatic t_wrap();
    int n, k;
    node_id = 8'd254;
    pulse_sw_reset();
    burst_len(n);
    wait_itt(3000, k);
    chk(itt_dest == 8'd254, "R4", "claim at 254", itt_dest, 254);
    @(negedge clk);
    wait_itt(1000, k);
    chk(itt_dest == 8'd255, "R6", "step to 255", itt_dest, 255);
    @(negedge clk);
    wait_itt(1000, k);
    chk(itt_dest == 8'd1 && next_id == 8'd1, "R6", "wrap skips 0", itt_dest, 1);
    node_id = 8'd250;
  endtask

  task automatic t_take_token();
    int n;
    logic [7:0] nid;
    pulse_sw_reset();
    burst_len(n);
    tx_pending = 1'b1;
    rx_itt_own = 1'b1;
    @(negedge clk);
    rx_itt_own = 1'b0;
    chk(have_token && enq_req, "R9", "token taken with enquiry", {have_token, enq_req}, 3);
    @(negedge clk);
    chk(!enq_req, "R9", "enquiry is one pulse", enq_req, 0);
    nid = next_id;
    repeat (10) @(negedge clk);
    chk(have_token && !itt_req, "R9", "token held until transfer ends", {have_token, itt_req}, 2);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done  = 1'b0;
    tx_pending = 1'b0;
    chk(itt_req && itt_dest == nid, "R9", "pass to next_id", itt_dest, nid);
    chk(!have_token, "R9", "token released on pass", have_token, 0);
    nid = next_id;
    rx_itt_own = 1'b1;
    @(negedge clk);
    rx_itt_own = 1'b0;
    chk(have_token && !enq_req, "R9", "token without pending", {have_token, enq_req}, 2);
    @(negedge clk);
    chk(itt_req && itt_dest == nid, "R9", "immediate pass", itt_dest, nid);
  endtask

  task automatic t_ignore_in_burst();
    int n;
    pulse_sw_reset();
    chk(burst_on && !itt_req && !have_token, "R1", "sw_reset starts burst", burst_on, 1);
    repeat (100) @(negedge clk);
    rx_itt_own = 1'b1; xfer_done = 1'b1; tx_pending = 1'b1;
    @(negedge clk);
    rx_itt_own = 1'b0; xfer_done = 1'b0; tx_pending = 1'b0;
    chk(!have_token && !enq_req && burst_on, "R11", "invite ignored in burst",
        {have_token, enq_req, burst_on}, 1);
    burst_len(n);
    chk(n >= 6780 && n <= 6790, "R11", "burst not cut short", n, 6785);
  endtask

  task automatic t_recon();
    int n, k;
    recon_sel   = 2'd1;
    line_active = 1'b1;
    pulse_sw_reset();
    burst_len(n);
    k = 0;
    while (!burst_on && k < 20000) begin
      @(negedge clk);
      k++;
    end
    chk(k >= 9000 && k <= 9003, "R10", "reconfiguration timeout", k, 9001);
    line_active = 1'b0;
    recon_sel   = 2'd0;
  endtask

  task automatic t_rate();
    int n;
    rate_sel = 3'd1;
    pulse_sw_reset();
    burst_len(n);
    chk(n >= 13770 && n <= 13773, "R8", "burst doubled at rate 1", n, 13770);
    rate_sel = 3'd0;
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b1; node_id = 8'd250; rate_sel = 3'd0; recon_sel = 2'd0;
    sw_reset = 1'b0; line_active = 1'b0; rx_itt_own = 1'b0; tx_pending = 1'b0;
    xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_burst();
    t_claim_and_sweep();
    t_backoff_restart();
    t_wrap();
    t_take_token();
    t_ignore_in_burst();
    t_recon();
    t_rate();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule